// File: doc/BRIEF.md
# Polyphase Halfband Decimate-by-Two Stage

This block halves the sample rate of a signed fixed-point stream. Its lowpass response is the square of a two-branch allpass halfband filter. The rate reduction happens at the input, so all filter arithmetic runs once per output sample rather than once per input sample.

Each incoming sample is accepted when `in_valid` is high. Accepted samples are grouped into pairs. The first sample of a pair is held. When the second sample arrives, the stage does three things in the same cycle:

- It feeds the second sample into two cascades: an alpha=0.125 cascade, and an alpha=0.5625 cascade followed by one extra output-rate delay.
- It feeds the held sample through an alpha=0.125 section followed by an alpha=0.5625 section. The result of this path is doubled.
- It adds the three results, multiplies the sum by one quarter, rounds it and saturates it to the input width.

Every section is a first-order allpass running at the output rate, `y = alpha*(x - y_prev) + x_prev`. The coefficients are applied by fixed shifts and adds, so there is no multiplier.

The stage is meant to sit in a chain of identical stages behind a one-bit or few-bit modulator front end. It can also be used alone as a clean two-times decimator for narrowband data.

Top module: `hpdec_stage`

## Requirements
- R1: Reset has three effects. `out_valid` drops to 0, `out_data` becomes 0 and all filter state is cleared. The first sample accepted after reset is always the first sample of a pair, even if reset arrived partway through a pair.
- R2: Exactly one output is produced for every two accepted samples. `out_valid` is high for one cycle, starting in the cycle after the second sample of the pair is accepted. Idle cycles between samples change neither the pairing nor the result, and `out_valid` is never high in two consecutive cycles.
- R3: `out_data` changes only in a cycle where `out_valid` is high; otherwise it holds its last value.
- R4: The DC gain is unity. A constant input settles to an output within 1 LSB of that input, for either sign.
- R5: The stage nulls an input at half the input sample rate. An input alternating +X, -X settles to an output within 1 LSB of zero.
- R6: Every output matches the ideal response within 1 LSB, clamped to the output range. The ideal response is 0.25 * (A1(A1(s)) + z^-1 A2(A2(s)) + 2 A2(A1(f))), where s is the second sample of each pair, f is the first, z^-1 is one output period, and each section has the form `y = alpha*(x - y_prev) + x_prev`.
- R7: Section A1 uses alpha = 0.125 and section A2 uses alpha = 0.5625. Both are realised with shifts and adds, and each product is rounded to nearest at the internal fraction width.
- R8: The final result saturates to the most positive or most negative `DATA_W`-bit value instead of wrapping.
- R9: For any input sequence within the `DATA_W` range, no allpass section output leaves the internal width `DATA_W+GUARD+FRAC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse per decimated sample |
| out_data | output | DATA_W | Signed decimated sample, registered |

## Verification
The most telling corner is the pairing. A stage that swaps the roles of the held and current samples, or that loses alignment after a reset arriving partway through a pair, still passes a DC input but fails the impulse and random comparisons against the ideal polyphase response.

A stage with the extra delay in the wrong path, or with a coefficient off by one LSB, also still passes the DC test. However, it leaves a residue on the alternating input and drifts from the ideal response.

A full-scale input built from the signs of the impulse response drives the true result past full scale. A stage that wraps instead of clamping then produces an output of the wrong sign.

Gaps in `in_valid` check that a stage does not count clock cycles instead of accepted samples.

// File: rtl/hpdec_pkg.sv
package hpdec_pkg;

  // Fixed coefficient selection for one allpass section.
  typedef enum logic [0:0] {
    COEF_EIGHTH        = 1'b0,  // alpha = 0.125  = 2^-3
    COEF_NINE_SIXTEENTH = 1'b1  // alpha = 0.5625 = 2^-1 + 2^-4
  } coef_e;

endpackage

// File: rtl/hpdec_phase_split.sv
module hpdec_phase_split #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                fire,
  output logic signed [W-1:0] held
);

  // High while waiting for the second sample of a pair.
  logic second;

  always_ff @(posedge clk) begin
    if (rst) begin
      second <= 1'b0;
      held   <= '0;
    end else if (in_valid) begin
      second <= ~second;
      if (!second) held <= in_data;
    end
  end

  assign fire = in_valid & second;

  // R2: pair position advances only on accepted samples.
  a_r2_phase_on_valid : assert property (@(posedge clk) disable iff (rst)
    !$stable(second) |-> $past(in_valid));

endmodule

// File: rtl/hpdec_allpass.sv
module hpdec_allpass #(
  parameter int              W    = 23,
  parameter hpdec_pkg::coef_e COEF = hpdec_pkg::COEF_EIGHTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);

  localparam int DW = W + 1;  // difference node
  localparam int PW = W + 6;  // product node with shift headroom
  localparam int YW = W + 2;  // sum node before narrowing

  logic signed [W-1:0]  x_prev;
  logic signed [W-1:0]  y_prev;
  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [YW-1:0] y_wide;

  assign diff = DW'(x) - DW'(y_prev);

  // R7: coefficient chosen at elaboration, realised by shift-add, rounded to nearest.
  generate
    if (COEF == hpdec_pkg::COEF_EIGHTH) begin : g_eighth
      assign prod = (PW'(diff) + PW'(4)) >>> 3;
    end else begin : g_nine_sixteenth
      assign prod = ((PW'(diff) <<< 3) + PW'(diff) + PW'(8)) >>> 4;
    end
  endgenerate

  assign y_wide = YW'(prod) + YW'(x_prev);
  assign y      = y_wide[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= '0;
      y_prev <= '0;
    end else if (en) begin
      x_prev <= x;
      y_prev <= y;
    end
  end

  // R9: the section result never needs more than the internal width.
  a_r9_no_overflow : assert property (@(posedge clk) disable iff (rst)
    en |-> (y_wide == YW'(y)));

endmodule

// File: rtl/hpdec_stage.sv
module hpdec_stage #(
  parameter int DATA_W = 16,
  parameter int GUARD  = 3,
  parameter int FRAC   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int IW = DATA_W + GUARD + FRAC;
  localparam int SW = IW + 3;
  localparam logic signed [SW-1:0] HALF_Q = SW'(1) <<< (FRAC + 1);
  localparam logic signed [SW-1:0] MAX_V  = SW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_V  = -SW'(1 << (DATA_W - 1));

  logic                     fire;
  logic signed [DATA_W-1:0] held;
  logic signed [IW-1:0]     up_in, lo_in;
  logic signed [IW-1:0]     a1_mid, a1a1, a2_mid, a2a2, lo_mid, a1a2;
  logic signed [IW-1:0]     a2a2_q;
  logic signed [SW-1:0]     sum, rnd;
  logic signed [DATA_W-1:0] sat;

  hpdec_phase_split #(.W(DATA_W)) u_split (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .fire(fire), .held(held)
  );

  // Second sample of the pair drives the upper path, the held one the lower.
  assign up_in = IW'(in_data) <<< FRAC;
  assign lo_in = IW'(held) <<< FRAC;

  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_EIGHTH)) u_up_a1_0 (
    .clk(clk), .rst(rst), .en(fire), .x(up_in), .y(a1_mid));
  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_EIGHTH)) u_up_a1_1 (
    .clk(clk), .rst(rst), .en(fire), .x(a1_mid), .y(a1a1));
  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_NINE_SIXTEENTH)) u_up_a2_0 (
    .clk(clk), .rst(rst), .en(fire), .x(up_in), .y(a2_mid));
  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_NINE_SIXTEENTH)) u_up_a2_1 (
    .clk(clk), .rst(rst), .en(fire), .x(a2_mid), .y(a2a2));
  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_EIGHTH)) u_lo_a1 (
    .clk(clk), .rst(rst), .en(fire), .x(lo_in), .y(lo_mid));
  hpdec_allpass #(.W(IW), .COEF(hpdec_pkg::COEF_NINE_SIXTEENTH)) u_lo_a2 (
    .clk(clk), .rst(rst), .en(fire), .x(lo_mid), .y(a1a2));

  // One output-rate delay on the A2*A2 product.
  always_ff @(posedge clk) begin
    if (rst)       a2a2_q <= '0;
    else if (fire) a2a2_q <= a2a2;
  end

  assign sum = SW'(a1a1) + SW'(a2a2_q) + (SW'(a1a2) <<< 1);
  // Quarter scale and removal of the fraction bits in one rounded shift.
  assign rnd = (sum + HALF_Q) >>> (FRAC + 2);

  always_comb begin
    if (rnd > MAX_V)      sat = MAX_V[DATA_W-1:0];
    else if (rnd < MIN_V) sat = MIN_V[DATA_W-1:0];
    else                  sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= sat;
    end
  end

  // R2: at most one output per two accepted samples.
  a_r2_single_pulse : assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: an output follows an accepted sample.
  a_r2_follows_input : assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3: output data holds between pulses.
  a_r3_hold : assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R8: positive overrange clamps.
  a_r8_clamp_high : assert property (@(posedge clk) disable iff (rst)
    (fire && rnd > MAX_V) |=> (out_data == MAX_V[DATA_W-1:0]));

  // R8: negative overrange clamps.
  a_r8_clamp_low : assert property (@(posedge clk) disable iff (rst)
    (fire && rnd < MIN_V) |=> (out_data == MIN_V[DATA_W-1:0]));

endmodule

// File: tb/hpdec_stage_tb.sv
module hpdec_stage_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int MAXI = (1 << (DATA_W - 1)) - 1;
  localparam int MINI = -(1 << (DATA_W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [DATA_W-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpdec_stage #(.DATA_W(DATA_W), .GUARD(3), .FRAC(4)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Ideal real-valued reference of the polyphase structure.
  real ms_x[6];
  real ms_y[6];
  real m_d22;

  function automatic void model_reset();
    for (int i = 0; i < 6; i++) begin ms_x[i] = 0.0; ms_y[i] = 0.0; end
    m_d22 = 0.0;
  endfunction

  function automatic real ap(int i, real a, real x);
    real y;
    y = a * (x - ms_y[i]) + ms_x[i];
    ms_x[i] = x;
    ms_y[i] = y;
    return y;
  endfunction

  function automatic real model_step(real first, real second);
    real u11, u22, l12, s;
    u11 = ap(1, 0.125, ap(0, 0.125, second));
    u22 = ap(3, 0.5625, ap(2, 0.5625, second));
    l12 = ap(5, 0.5625, ap(4, 0.125, first));
    s = u11 + m_d22 + 2.0 * l12;
    m_d22 = u22;
    return 0.25 * s;
  endfunction

  function automatic real clampr(real v);
    if (v > MAXI) return MAXI;
    if (v < MINI) return MINI;
    return v;
  endfunction

  function automatic void check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic void check_near(string req, int act, real exp);
    real d;
    d = act - clampr(exp);
    check(d <= 1.0 && d >= -1.0, req, act, $rtoi(clampr(exp)));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Drives a pair, returns what the output shows one cycle after the second sample.
  task automatic push_pair(input int a, input int b, input int gap,
                           output bit got_v, output int got, output bit pre_v);
    @(negedge clk);
    in_valid = 1'b1; in_data = DATA_W'(a);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    pre_v = out_valid;
    in_valid = 1'b1; in_data = DATA_W'(b);
    @(negedge clk);
    in_valid = 1'b0;
    got_v = out_valid;
    got = out_data;
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_data == 0, "R1 reset data", out_data, 0);
  endtask

  task automatic t_cadence();
    bit v, pv; int d; real e;
    do_reset();
    push_pair(3000, -1200, 3, v, d, pv);
    e = model_step(3000, -1200);
    check(pv == 1'b0, "R2 no early pulse", pv, 0);
    check(v == 1'b1, "R2 pulse after pair", v, 1);
    check_near("R6 first output", d, e);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single cycle pulse", out_valid, 0);
    repeat (4) @(negedge clk);
    check(out_data == DATA_W'(d), "R3 data held", out_data, d);
    push_pair(-500, 7000, 0, v, d, pv);
    e = model_step(-500, 7000);
    check(v == 1'b1, "R2 back to back pair", v, 1);
    check_near("R6 gapless pair", d, e);
  endtask

  task automatic t_dc(input int level);
    bit v, pv; int d;
    do_reset();
    for (int i = 0; i < 40; i++) push_pair(level, level, i % 2, v, d, pv);
    check(d - level <= 1 && level - d <= 1, "R4 unity DC gain", d, level);
  endtask

  task automatic t_nyquist();
    bit v, pv; int d;
    do_reset();
    for (int i = 0; i < 40; i++) push_pair(10000, -10000, 0, v, d, pv);
    check(d <= 1 && d >= -1, "R5 half-rate null", d, 0);
  endtask

  task automatic t_impulse(input bit on_first);
    bit v, pv; int d; real e; int bad;
    do_reset();
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      int a, b;
      a = (i == 0 && on_first) ? 16000 : 0;
      b = (i == 0 && !on_first) ? 16000 : 0;
      push_pair(a, b, 0, v, d, pv);
      e = model_step(a, b);
      check_near(on_first ? "R7 impulse held path" : "R7 impulse upper path", d, e);
    end
  endtask

  task automatic t_random();
    bit v, pv; int d; real e;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      int a, b;
      a = int'($urandom_range(40000)) - 20000;
      b = int'($urandom_range(40000)) - 20000;
      push_pair(a, b, int'($urandom_range(2)), v, d, pv);
      e = model_step(a, b);
      check_near("R6 random stream", d, e);
    end
  endtask

  task automatic t_realign();
    bit v, pv; int d; real e;
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_data = DATA_W'(9000);
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    push_pair(16000, 0, 0, v, d, pv);
    e = model_step(16000, 0);
    check(v == 1'b1, "R1 pair realigned", v, 1);
    check_near("R1 state cleared", d, e);
  endtask

  task automatic t_saturate();
    int pat[32]; bit v, pv; int d; real e, g;
    for (int p = 0; p < 32; p++) begin
      model_reset();
      g = 0.0;
      for (int m = 0; m < 16; m++)
        g = model_step((2*m == p) ? 1.0 : 0.0, (2*m+1 == p) ? 1.0 : 0.0);
      pat[p] = (g >= 0.0) ? MAXI : MINI;
    end
    do_reset();
    for (int m = 0; m < 16; m++) begin
      push_pair(pat[2*m], pat[2*m+1], 0, v, d, pv);
      e = model_step(pat[2*m], pat[2*m+1]);
      check_near("R9 full-scale stream", d, e);
    end
    if (e > MAXI + 1.0) check(d == MAXI, "R8 clamp high", d, MAXI);
    for (int p = 0; p < 32; p++) pat[p] = (pat[p] == MAXI) ? MINI : MAXI;
    do_reset();
    for (int m = 0; m < 16; m++) begin
      push_pair(pat[2*m], pat[2*m+1], 0, v, d, pv);
      e = model_step(pat[2*m], pat[2*m+1]);
    end
    if (e < MINI - 1.0) check(d == MINI, "R8 clamp low", d, MINI);
    else check_near("R8 negative full scale", d, e);
  endtask

  initial begin
    model_reset();
    t_reset();
    t_cadence();
    t_dc(12000);
    t_dc(-9000);
    t_nyquist();
    t_impulse(1'b0);
    t_impulse(1'b1);
    t_random();
    t_realign();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule